// File: doc/BRIEF.md
# Configurable PLD I/O Cell

This block is one programmable pad cell of a logic device. It joins an internal output signal from the core, an internal input path back to the core and a bidirectional pad. The pad is modelled as three separate signals: pad in, pad out and output enable. A static mode setting picks one of five behaviours:

- combinational input
- combinational output
- registered input
- registered output
- bidirectional

In the two registered modes a single storage bit sits in the path.

The cell has five controls: register clock, clock enable, output enable, register reset and register preset. Each control is chosen independently. The source is either a line of the 8-bit control bus for the cell's edge of the device, or a dedicated global pin for that control, or a constant inactive level. After selection, each control's polarity can be inverted on its own.

The chosen register clock is not used as a clock net. It is sampled by the cell's system clock `clk_i`, and its rising edge is detected there, so no clock is ever gated or muxed. Reset and preset act asynchronously on the storage bit, and reset has priority.

Top module: `pld_io_cell`

## Requirements
- R1: While `rst_ni` is low the storage bit is 0, so in registered-output mode `pad_out_o` is 0 and in registered-input mode `core_in_o` is 0.
- R2: Mode code 0 (combinational input) gives `core_in_o` = `pad_in_i`, `pad_oe_o` = 0 and `pad_out_o` = 0, whatever the output-enable selection.
- R3: Mode code 1 (combinational output) gives `pad_out_o` = `core_out_i`, `pad_oe_o` = the active output-enable control, and `core_in_o` = 0.
- R4: Mode code 2 (registered input) gives `core_in_o` = storage bit and `pad_oe_o` = 0. The bit loads `pad_in_i` at the first `clk_i` rising edge at which the selected clock is sampled high after having been sampled low, and not before.
- R5: Mode code 3 (registered output) gives `pad_out_o` = storage bit loaded from `core_out_i`, and `pad_oe_o` = the active output-enable control. A change of `core_out_i` without a clock edge leaves `pad_out_o` unchanged.
- R6: Mode code 4 (bidirectional) gives `pad_out_o` = `core_out_i` and `pad_oe_o` = the active output-enable control. `core_in_o` = `pad_in_i` at all times, including while the pad is driven.
- R7: Each control has a 4-bit select in `cfg_sel_i`, with slices in this order: 0 clock, 1 clock enable, 2 output enable, 3 reset, 4 preset. Codes 0–7 pick bus line `ctl_bus_i[code]`. Code 8 picks `glb_ctl_i[slice]`. Codes 9–15 give a constant inactive control.
- R8: Bit k of `cfg_inv_i` inverts the control of slice k after selection. It has no effect for codes 9–15.
- R9: A clock edge is ignored while the active clock enable is 0. A clock-enable select of 9–15 leaves the register always enabled.
- R10: The active reset clears the storage bit and the active preset sets it, both without waiting for a clock edge. Reset wins when both are active.
- R11: Mode codes 5–7 drive `pad_oe_o`, `pad_out_o` and `core_in_o` to 0.
- R12: Holding the selected clock high gives exactly one load. A new load needs the clock to be sampled low first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the selected register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | I/O mode code (0–7) |
| cfg_sel_i | input | 20 | Five 4-bit control selects: clock, enable, output enable, reset, preset |
| cfg_inv_i | input | 5 | Per-control polarity inversion, same slice order |
| ctl_bus_i | input | 8 | Control bus of this cell's device edge |
| glb_ctl_i | input | 5 | Global control pins, one per control slice |
| core_out_i | input | 1 | Output signal from the core logic |
| core_in_o | output | 1 | Input path to the core logic |
| pad_in_i | input | 1 | Value seen at the pad |
| pad_out_o | output | 1 | Value driven to the pad |
| pad_oe_o | output | 1 | Pad output enable |

## Verification
All combinational paths are checked in the same clock period as the stimulus: inputs change on a falling edge and outputs are read two time units later. That is before the next rising edge.

A register load is due at the first rising edge after the selected clock is seen high. The bench therefore raises the bus line on a falling edge, reads the output once before that rising edge to show nothing has moved, and reads it again on the next falling edge. Reset and preset are applied one time unit after a falling edge and read one unit later, so no clock edge can explain the change.

// File: rtl/pld_io_pkg.sv
package pld_io_pkg;
  localparam int unsigned N_FN = 5;

  typedef enum logic [2:0] {
    IO_CIN   = 3'd0,
    IO_COUT  = 3'd1,
    IO_RIN   = 3'd2,
    IO_ROUT  = 3'd3,
    IO_BIDIR = 3'd4
  } io_mode_e;

  // control slice order inside cfg_sel_i / cfg_inv_i / glb_ctl_i
  localparam int unsigned FN_CLK = 0;
  localparam int unsigned FN_CE  = 1;
  localparam int unsigned FN_OE  = 2;
  localparam int unsigned FN_RST = 3;
  localparam int unsigned FN_SET = 4;
endpackage

// File: rtl/pld_ctl_sel.sv
module pld_ctl_sel #(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned SEL_W = 4
) (
  input  logic [BUS_W-1:0] bus_i,
  input  logic             glb_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             inv_i,
  output logic             act_o,
  output logic             used_o
);
  localparam int unsigned IDX_W = (BUS_W > 1) ? $clog2(BUS_W) : 1;
  localparam logic [SEL_W-1:0] GLB_CODE = SEL_W'(BUS_W);

  logic raw;

  always_comb begin
    raw    = 1'b0;
    used_o = 1'b1;
    if (sel_i < GLB_CODE)       raw = bus_i[IDX_W'(sel_i)];
    else if (sel_i == GLB_CODE) raw = glb_i;
    else                        used_o = 1'b0;
  end

  // polarity after selection; unused codes stay inactive
  assign act_o = used_o & (raw ^ inv_i);
endmodule

// File: rtl/pld_io_reg.sv
module pld_io_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cclk_i,
  input  logic ce_i,
  input  logic clr_i,
  input  logic set_i,
  input  logic d_i,
  output logic q_o,
  output logic tick_o
);
  logic cclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cclk_q <= 1'b0;
    else         cclk_q <= cclk_i;
  end

  assign tick_o = cclk_i & ~cclk_q & ce_i;

  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i or posedge set_i) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (clr_i)  q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (tick_o) q_o <= d_i;
  end
endmodule

// File: rtl/pld_io_cell.sv
module pld_io_cell
  import pld_io_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned SEL_W = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [2:0]                 mode_i,
  input  logic [N_FN-1:0][SEL_W-1:0] cfg_sel_i,
  input  logic [N_FN-1:0]            cfg_inv_i,
  input  logic [BUS_W-1:0]           ctl_bus_i,
  input  logic [N_FN-1:0]            glb_ctl_i,
  input  logic                       core_out_i,
  output logic                       core_in_o,
  input  logic                       pad_in_i,
  output logic                       pad_out_o,
  output logic                       pad_oe_o
);
  logic [N_FN-1:0] fn_act;
  logic [N_FN-1:0] fn_used;

  for (genvar g = 0; g < N_FN; g++) begin : g_fn
    pld_ctl_sel #(.BUS_W(BUS_W), .SEL_W(SEL_W)) u_sel (
      .bus_i  (ctl_bus_i),
      .glb_i  (glb_ctl_i[g]),
      .sel_i  (cfg_sel_i[g]),
      .inv_i  (cfg_inv_i[g]),
      .act_o  (fn_act[g]),
      .used_o (fn_used[g])
    );
  end

  logic ce_act, oe_act, clr_act, set_act, tick, reg_q, reg_d;

  // an unused enable leaves the register always enabled
  assign ce_act  = fn_used[FN_CE] ? fn_act[FN_CE] : 1'b1;
  assign oe_act  = fn_act[FN_OE];
  assign clr_act = fn_act[FN_RST];
  assign set_act = fn_act[FN_SET];
  assign reg_d   = (mode_i == IO_ROUT) ? core_out_i : pad_in_i;

  pld_io_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cclk_i (fn_act[FN_CLK]),
    .ce_i   (ce_act),
    .clr_i  (clr_act),
    .set_i  (set_act),
    .d_i    (reg_d),
    .q_o    (reg_q),
    .tick_o (tick)
  );

  always_comb begin
    pad_out_o = 1'b0;
    pad_oe_o  = 1'b0;
    core_in_o = 1'b0;
    case (mode_i)
      IO_CIN:   core_in_o = pad_in_i;
      IO_COUT:  begin pad_out_o = core_out_i; pad_oe_o = oe_act; end
      IO_RIN:   core_in_o = reg_q;
      IO_ROUT:  begin pad_out_o = reg_q;      pad_oe_o = oe_act; end
      IO_BIDIR: begin
        pad_out_o = core_out_i;
        pad_oe_o  = oe_act;
        core_in_o = pad_in_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pld_io_cell_chk.sv
module pld_io_cell_chk #(
  parameter int unsigned SEL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       mode_i,
  input logic [SEL_W-1:0] sel_oe,
  input logic             pad_in_i,
  input logic             pad_oe_o,
  input logic             pad_out_o,
  input logic             core_in_o,
  input logic             clr_act,
  input logic             set_act,
  input logic             tick,
  input logic             q
);
  AST_INPUT_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd0 || mode_i == 3'd2) |-> !pad_oe_o); // R2

  AST_BIDIR_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd4) |-> (core_in_o == pad_in_i)); // R6

  AST_OE_CONST_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_oe > SEL_W'(8)) |-> !pad_oe_o); // R7

  AST_RESET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_act |-> !q); // R10

  AST_SPARE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i >= 3'd5) |-> (!pad_oe_o && !pad_out_o && !core_in_o)); // R11

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_act || set_act)
    !tick |=> $stable(q)); // R12
endmodule

bind pld_io_cell pld_io_cell_chk #(.SEL_W(SEL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .sel_oe    (cfg_sel_i[2]),
  .pad_in_i  (pad_in_i),
  .pad_oe_o  (pad_oe_o),
  .pad_out_o (pad_out_o),
  .core_in_o (core_in_o),
  .clr_act   (clr_act),
  .set_act   (set_act),
  .tick      (tick),
  .q         (reg_q)
);

// File: tb/pld_io_cell_test.sv
module pld_io_cell_test;
  localparam int CLK_P = 10;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [2:0]      mode_i;
  logic [4:0][3:0] cfg_sel_i;
  logic [4:0]      cfg_inv_i;
  logic [7:0]      ctl_bus_i;
  logic [4:0]      glb_ctl_i;
  logic            core_out_i, pad_in_i;
  logic            core_in_o, pad_out_o, pad_oe_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  pld_io_cell uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .cfg_sel_i(cfg_sel_i),
    .cfg_inv_i(cfg_inv_i), .ctl_bus_i(ctl_bus_i), .glb_ctl_i(glb_ctl_i),
    .core_out_i(core_out_i), .core_in_o(core_in_o), .pad_in_i(pad_in_i),
    .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o)
  );

  typedef struct packed {
    logic [2:0] mode;
    logic [3:0] sel;
    logic       inv;
    logic [7:0] bus;
    logic       co, pi, goe;
    logic       eoe, eout, ein;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 4'd15, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R2
    '{3'd0, 4'd3,  1'b0, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R2
    '{3'd1, 4'd2,  1'b0, 8'h04, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R3
    '{3'd1, 4'd2,  1'b0, 8'hFB, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R3
    '{3'd1, 4'd2,  1'b1, 8'hFB, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R8
    '{3'd1, 4'd8,  1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R7
    '{3'd1, 4'd8,  1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R8
    '{3'd1, 4'd15, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R7
    '{3'd1, 4'd12, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R7
    '{3'd4, 4'd7,  1'b0, 8'h80, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // R6
    '{3'd4, 4'd7,  1'b0, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R6
    '{3'd4, 4'd7,  1'b0, 8'h7F, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R6
    '{3'd5, 4'd0,  1'b0, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R11
    '{3'd7, 4'd8,  1'b0, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}  // R11
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // drive selected clock (bus line 0) low, then high; result due by next falling edge
  task automatic cclk_pulse();
    ctl_bus_i[0] = 1'b0;
    @(negedge clk_i);
    ctl_bus_i[0] = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_P * 5000);
    failures++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mode_i = 3'd3;
    cfg_sel_i = '{default: 4'd15};
    cfg_sel_i[2] = 4'd8;
    cfg_inv_i = '0;
    ctl_bus_i = '0;
    glb_ctl_i = 5'b00100;
    core_out_i = 1'b1;
    pad_in_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 pad_out in reset", pad_out_o, 1'b0);
    check("R1 oe passes in reset", pad_oe_o, 1'b1);
    mode_i = 3'd2;
    #1 check("R1 core_in in reset", core_in_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // combinational table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      mode_i       = VEC[i].mode;
      cfg_sel_i[2] = VEC[i].sel;
      cfg_inv_i[2] = VEC[i].inv;
      ctl_bus_i    = VEC[i].bus;
      core_out_i   = VEC[i].co;
      pad_in_i     = VEC[i].pi;
      glb_ctl_i[2] = VEC[i].goe;
      #2;
      check($sformatf("R2/R3/R6/R7/R8/R11 vec%0d oe", i), pad_oe_o, VEC[i].eoe);
      check($sformatf("R2/R3/R6/R7/R8/R11 vec%0d out", i), pad_out_o, VEC[i].eout);
      check($sformatf("R2/R3/R6/R7/R8/R11 vec%0d in", i), core_in_o, VEC[i].ein);
    end

    // registered input: clock = bus line 0
    @(negedge clk_i);
    mode_i = 3'd2;
    cfg_sel_i = '{default: 4'd15};
    cfg_sel_i[0] = 4'd0;
    cfg_inv_i = '0;
    ctl_bus_i = '0;
    glb_ctl_i = '0;
    pad_in_i = 1'b1;
    @(negedge clk_i);
    ctl_bus_i[0] = 1'b1;
    #2 check("R4 no load before edge", core_in_o, 1'b0);
    @(negedge clk_i);
    check("R4 load pad_in", core_in_o, 1'b1);
    check("R4 no drive", pad_oe_o, 1'b0);
    pad_in_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R12 held clock loads once", core_in_o, 1'b1);
    cclk_pulse();
    check("R12 reload after low", core_in_o, 1'b0);

    // clock enable on bus line 1
    cfg_sel_i[1] = 4'd1;
    ctl_bus_i[1] = 1'b0;
    pad_in_i = 1'b1;
    cclk_pulse();
    check("R9 disabled edge ignored", core_in_o, 1'b0);
    ctl_bus_i[1] = 1'b1;
    cclk_pulse();
    check("R9 enabled edge loads", core_in_o, 1'b1);
    cfg_sel_i[1] = 4'd8;
    glb_ctl_i[1] = 1'b0;
    cfg_inv_i[1] = 1'b1;
    pad_in_i = 1'b0;
    cclk_pulse();
    check("R8 inverted global enable", core_in_o, 1'b0);

    // async preset on bus line 5, reset on global pin
    cfg_sel_i[4] = 4'd5;
    cfg_sel_i[3] = 4'd8;
    #1 ctl_bus_i[5] = 1'b1;
    #1 check("R10 async preset", core_in_o, 1'b1);
    glb_ctl_i[3] = 1'b1;
    #1 check("R10 reset wins", core_in_o, 1'b0);
    @(negedge clk_i);
    check("R10 reset holds with preset", core_in_o, 1'b0);
    ctl_bus_i[5] = 1'b0;
    glb_ctl_i[3] = 1'b0;

    // registered output, oe on bus line 4
    @(negedge clk_i);
    mode_i = 3'd3;
    cfg_sel_i[1] = 4'd15;
    cfg_sel_i[2] = 4'd4;
    ctl_bus_i[4] = 1'b1;
    core_out_i = 1'b1;
    #2 check("R5 not loaded yet", pad_out_o, 1'b0);
    @(negedge clk_i);
    cclk_pulse();
    check("R5 load core_out", pad_out_o, 1'b1);
    check("R5 oe active", pad_oe_o, 1'b1);
    core_out_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R5 hold without edge", pad_out_o, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule